// File: doc/BRIEF.md
# Program Counter Sequencer with Skip and Return Stack

This block owns the program counter of a small controller core. Once per accepted instruction it chooses the next PC from one of these sources:

- a plain increment;
- an increment by two when the execute unit asks to skip the following instruction;
- a computed jump that adds the accumulator to the low PC byte;
- a pop of an eight-entry hardware return stack, for a return or a return from interrupt;
- a call target handed in by the surrounding decoder, which pushes the return address.

Instructions that need a second cycle make the block busy for exactly one cycle. During that cycle fetch must hold off, and any instruction presented is ignored. The cycle count of the presented instruction is given on `op_cycles`, so that fetch can plan the stall ahead of time. For a taken skip, the second cycle is an idle slot. It is flagged on `idle_slot` so that the pipeline can squash the skipped word.

The control is a three-state machine:

- `ST_RUN`: the block accepts an instruction.
- `ST_HOLD`: the second cycle of a return, an interrupt return or a table jump.
- `ST_SKIP`: the idle slot of a taken skip.

The transitions are:

- `RUN->HOLD` on an accepted return, interrupt return or table jump.
- `RUN->SKIP` on an accepted skip-class instruction whose skip request is high.
- `RUN->RUN` on anything else.
- `HOLD->RUN` and `SKIP->RUN` unconditionally after one cycle.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted and right after it is released, `pc` is 0, `busy` is 0, `idle_slot` is 0 and `int_en` is 0. The return stack pointer is also cleared.
- R2: An accepted instruction not listed in R3 to R7 advances `pc` by 1, modulo 2^11, so 0x7FF becomes 0x000. It leaves `busy` low.
- R3: The skip-class words are those with bits [12:6] equal to 0x16, 0x17, 0x1E or 0x1F. A skip-class word accepted with `skip_req` high advances `pc` by 2 and raises `busy` and `idle_slot` for one cycle. A skip-class word accepted with `skip_req` low advances `pc` by 1. `skip_req` has no effect on any other word.
- R4: An accepted `call_req` loads `pc` with `call_target` and pushes the old `pc`+1 onto the return stack. It takes one cycle, and the opcode presented with it is not decoded.
- R5: Opcode 0x0012 loads `pc` with the top of the return stack and pops it. `busy` is high for one cycle, `idle_slot` stays low and `int_en` does not change.
- R6: Opcode 0x0013 behaves as R5 and also sets `int_en`. `int_en` then stays set until reset.
- R7: Opcode 0x0020 first forms `pc`+1. It replaces that value's bits [7:0] with their 8-bit sum with `acc`, dropping the carry, and keeps its bits [10:8]. `busy` is high for one cycle.
- R8: While `busy` is high, `issue` and all other instruction inputs are ignored, and `pc` holds.
- R9: The return stack is last-in first-out and 8 entries deep. A ninth push without a pop overwrites the oldest entry, and the pointer wraps in both directions.
- R10: `op_cycles` is 0 when `issue` is low or `busy` is high. Otherwise it is 2 for opcode 0x0012, 0x0013 or 0x0020, or for a skip-class word with `skip_req` high, and 1 for everything else, including a call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | An instruction is presented this cycle |
| op_word | input | 13 | Instruction word |
| acc | input | 8 | Accumulator value for the table jump |
| skip_req | input | 1 | Skip condition from the execute unit |
| call_req | input | 1 | Decoded call presented with this instruction |
| call_target | input | 11 | Call destination address |
| pc | output | 11 | Program counter |
| op_cycles | output | 2 | Cycle count of the presented instruction |
| busy | output | 1 | Second cycle of a two-cycle instruction; fetch stalls |
| idle_slot | output | 1 | Second cycle is the idle slot of a taken skip |
| int_en | output | 1 | Global interrupt enable |

## Verification
A wrong state code shows on `busy` and `idle_slot` one cycle after the instruction that caused it. It also shows on `pc` failing to hold, or failing to move, in the cycle after that. A stack pointer that is off by one, or that does not wrap, stays hidden until the next return. That return loads an address other than the pushed one, which is why the test runs nine nested calls before unwinding them. A carry from the table-jump add that leaks into the upper bits is only visible when the low byte overflows, so the test includes such a case.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_SKIP = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        K_STEP = 3'd0,
        K_SKIP = 3'd1,
        K_RET  = 3'd2,
        K_RETI = 3'd3,
        K_TBL  = 3'd4,
        K_CALL = 3'd5
    } op_kind_e;

    localparam logic [12:0] OPC_RET  = 13'h0012;
    localparam logic [12:0] OPC_RETI = 13'h0013;
    localparam logic [12:0] OPC_TBL  = 13'h0020;

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
    import pcs_pkg::*;
#(
    parameter int OP_W = 13
) (
    input  logic [OP_W-1:0] op_word,
    input  logic            skip_req,
    input  logic            call_req,
    output op_kind_e        kind,
    output logic [1:0]      cycles
);

    logic skip_class;

    // Skip-class words: upper two bits zero, and bits 10, 8 and 7 all set.
    assign skip_class = (op_word[12:11] == 2'b00) && op_word[10] && op_word[8] && op_word[7];

    always_comb begin
        if (call_req) begin
            kind = K_CALL;
        end else if (op_word == OP_W'(OPC_RET)) begin
            kind = K_RET;
        end else if (op_word == OP_W'(OPC_RETI)) begin
            kind = K_RETI;
        end else if (op_word == OP_W'(OPC_TBL)) begin
            kind = K_TBL;
        end else if (skip_class && skip_req) begin
            kind = K_SKIP;
        end else begin
            kind = K_STEP;
        end
    end

    always_comb begin
        unique case (kind)
            K_RET, K_RETI, K_TBL, K_SKIP: cycles = 2'd2;
            default:                      cycles = 2'd1;
        endcase
    end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
    parameter int W     = 11,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top
);

    localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_dec;
    logic [W-1:0]    slot_q [DEPTH];

    assign sp_dec = sp_q - 1'b1;
    assign top    = slot_q[sp_dec];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (push) begin
            sp_q <= sp_q + 1'b1;
        end else if (pop) begin
            sp_q <= sp_dec;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (push && (sp_q == SP_W'(g))) begin
                slot_q[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/pcs_nextpc.sv
module pcs_nextpc
    import pcs_pkg::*;
#(
    parameter int PC_W  = 11,
    parameter int ACC_W = 8
) (
    input  op_kind_e         kind,
    input  logic [PC_W-1:0]  pc,
    input  logic [ACC_W-1:0] acc,
    input  logic [PC_W-1:0]  call_target,
    input  logic [PC_W-1:0]  stack_top,
    output logic [PC_W-1:0]  pc_next,
    output logic [PC_W-1:0]  ret_addr
);

    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] pc_tbl;

    assign pc_inc   = pc + 1'b1;
    assign ret_addr = pc_inc;

    if (PC_W > ACC_W) begin : g_tbl_split
        assign pc_tbl = {pc_inc[PC_W-1:ACC_W], pc_inc[ACC_W-1:0] + acc};
    end else begin : g_tbl_full
        assign pc_tbl = pc_inc + PC_W'(acc);
    end

    always_comb begin
        unique case (kind)
            K_SKIP:        pc_next = pc + PC_W'(2);
            K_RET, K_RETI: pc_next = stack_top;
            K_TBL:         pc_next = pc_tbl;
            K_CALL:        pc_next = call_target;
            default:       pc_next = pc_inc;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcs_pkg::*;
#(
    parameter int PC_W      = 11,
    parameter int ACC_W     = 8,
    parameter int OP_W      = 13,
    parameter int STK_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [OP_W-1:0]  op_word,
    input  logic [ACC_W-1:0] acc,
    input  logic             skip_req,
    input  logic             call_req,
    input  logic [PC_W-1:0]  call_target,
    output logic [PC_W-1:0]  pc,
    output logic [1:0]       op_cycles,
    output logic             busy,
    output logic             idle_slot,
    output logic             int_en
);

    seq_state_e      state_q, state_d;
    op_kind_e        kind;
    logic [1:0]      kind_cycles;
    logic            accept;
    logic            push, pop;
    logic [PC_W-1:0] pc_next, ret_addr, stack_top;

    assign accept = issue && (state_q == ST_RUN);
    assign push   = accept && (kind == K_CALL);
    assign pop    = accept && ((kind == K_RET) || (kind == K_RETI));

    pcs_decode #(.OP_W(OP_W)) u_decode (
        .op_word  (op_word),
        .skip_req (skip_req),
        .call_req (call_req),
        .kind     (kind),
        .cycles   (kind_cycles)
    );

    pcs_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (ret_addr),
        .top   (stack_top)
    );

    pcs_nextpc #(.PC_W(PC_W), .ACC_W(ACC_W)) u_nextpc (
        .kind        (kind),
        .pc          (pc),
        .acc         (acc),
        .call_target (call_target),
        .stack_top   (stack_top),
        .pc_next     (pc_next),
        .ret_addr    (ret_addr)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (accept) begin
                    unique case (kind)
                        K_RET, K_RETI, K_TBL: state_d = ST_HOLD;
                        K_SKIP:               state_d = ST_SKIP;
                        default:              state_d = ST_RUN;
                    endcase
                end
            end
            ST_HOLD: state_d = ST_RUN;
            ST_SKIP: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered datapath: PC and interrupt enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc     <= '0;
            int_en <= 1'b0;
        end else if (accept) begin
            pc <= pc_next;
            if (kind == K_RETI) begin
                int_en <= 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        busy      = (state_q != ST_RUN);
        idle_slot = (state_q == ST_SKIP);
        op_cycles = accept ? kind_cycles : 2'd0;
    end

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
    parameter int PC_W  = 11,
    parameter int ACC_W = 8,
    parameter int OP_W  = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue,
    input logic [OP_W-1:0]  op_word,
    input logic [ACC_W-1:0] acc,
    input logic             skip_req,
    input logic             call_req,
    input logic [PC_W-1:0]  call_target,
    input logic [PC_W-1:0]  pc,
    input logic [1:0]       op_cycles,
    input logic             busy,
    input logic             idle_slot,
    input logic             int_en
);

    logic            acc_ok;
    logic            skip_word;
    logic [PC_W-1:0] pc_inc;

    assign acc_ok    = issue && !busy && !call_req;
    assign skip_word = (op_word[12:6] == 7'h16) || (op_word[12:6] == 7'h17) ||
                       (op_word[12:6] == 7'h1E) || (op_word[12:6] == 7'h1F);
    assign pc_inc    = pc + 1'b1;

    // R8: the PC holds while busy
    p_hold_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pc));

    // R3 and R5: the second cycle lasts exactly one cycle
    p_busy_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_skip_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && skip_word && skip_req) |=> (idle_slot && (pc == PC_W'($past(pc) + PC_W'(2)))));

    p_ret_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && (op_word == OP_W'(13'h0012))) |=> (busy && !idle_slot && $stable(int_en)));

    p_reti_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && (op_word == OP_W'(13'h0013))) |=> (busy && int_en));

    p_ie_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_en |=> int_en);

    p_tbl_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && (op_word == OP_W'(13'h0020))) |=>
            ((pc[PC_W-1:ACC_W] == $past(pc_inc[PC_W-1:ACC_W])) &&
             (pc[ACC_W-1:0] == ACC_W'($past(pc_inc[ACC_W-1:0]) + $past(acc)))));

    p_call_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !busy && call_req) |=> ((pc == $past(call_target)) && !busy));

    // R10
    p_cycles_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue || busy) |-> (op_cycles == 2'd0));

    // R1
    always_comb begin
        if (!rst_n) begin
            a_reset_r1: assert (pc == '0 && !busy && !idle_slot && !int_en);
        end
    end

endmodule

bind pc_sequencer pcs_checker #(.PC_W(PC_W), .ACC_W(ACC_W), .OP_W(OP_W)) u_pcs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue),
    .op_word     (op_word),
    .acc         (acc),
    .skip_req    (skip_req),
    .call_req    (call_req),
    .call_target (call_target),
    .pc          (pc),
    .op_cycles   (op_cycles),
    .busy        (busy),
    .idle_slot   (idle_slot),
    .int_en      (int_en)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [12:0] op_word = '0;
    logic [7:0]  acc = '0;
    logic        skip_req = 1'b0;
    logic        call_req = 1'b0;
    logic [10:0] call_target = '0;
    logic [10:0] pc;
    logic [1:0]  op_cycles;
    logic        busy, idle_slot, int_en;

    int checks = 0;
    int failures = 0;

    typedef struct packed {
        logic [10:0] pc;
        logic        busy;
        logic        idle;
        logic        ie;
        logic [7:0]  rq;
    } exp_t;

    exp_t exp_q[$];

    // Reference model state
    logic [10:0] mpc = '0;
    logic        mbusy = 1'b0;
    logic        mie = 1'b0;
    logic [10:0] mstk [8];
    int          msp = 0;

    pc_sequencer dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op_word(op_word), .acc(acc),
        .skip_req(skip_req), .call_req(call_req), .call_target(call_target),
        .pc(pc), .op_cycles(op_cycles), .busy(busy), .idle_slot(idle_slot), .int_en(int_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit is_skip_word(logic [12:0] w);
        return (w[12:6] == 7'h16) || (w[12:6] == 7'h17) || (w[12:6] == 7'h1E) || (w[12:6] == 7'h1F);
    endfunction

    task automatic check(bit ok, int rq, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    // Driver: applies one cycle of stimulus, checks op_cycles (R10), pushes the expected post-edge state.
    task automatic step(bit iss, logic [12:0] op, logic [7:0] a, bit sk, bit cl, logic [10:0] tg, int rq);
        logic [1:0] ecyc;
        logic       nbusy, nidle;
        @(negedge clk);
        #2;
        issue = iss; op_word = op; acc = a; skip_req = sk; call_req = cl; call_target = tg;
        #1;
        ecyc = 2'd0;
        if (iss && !mbusy) begin
            if (cl) ecyc = 2'd1;
            else if (op == 13'h0012 || op == 13'h0013 || op == 13'h0020) ecyc = 2'd2;
            else if (is_skip_word(op) && sk) ecyc = 2'd2;
            else ecyc = 2'd1;
        end
        check(op_cycles == ecyc, 10, "op_cycles", int'(op_cycles), int'(ecyc)); // R10
        nbusy = 1'b0;
        nidle = 1'b0;
        if (!mbusy && iss) begin
            if (cl) begin
                mstk[msp] = mpc + 11'd1;
                msp = (msp + 1) % 8;
                mpc = tg;
            end else if (op == 13'h0012 || op == 13'h0013) begin
                msp = (msp + 7) % 8;
                mpc = mstk[msp];
                nbusy = 1'b1;
                if (op == 13'h0013) mie = 1'b1;
            end else if (op == 13'h0020) begin
                logic [10:0] base;
                base = mpc + 11'd1;
                mpc = {base[10:8], base[7:0] + a};
                nbusy = 1'b1;
            end else if (is_skip_word(op) && sk) begin
                mpc = mpc + 11'd2;
                nbusy = 1'b1;
                nidle = 1'b1;
            end else begin
                mpc = mpc + 11'd1;
            end
        end
        mbusy = nbusy;
        exp_q.push_back('{pc: mpc, busy: nbusy, idle: nidle, ie: mie, rq: 8'(rq)});
    endtask

    task automatic plain(logic [12:0] op, int rq);
        step(1'b1, op, 8'h00, 1'b0, 1'b0, 11'h000, rq);
    endtask

    task automatic call_to(logic [10:0] tg, int rq);
        step(1'b1, 13'h0000, 8'h00, 1'b0, 1'b1, tg, rq);
    endtask

    task automatic gap(int rq);
        step(1'b0, 13'h0000, 8'h00, 1'b0, 1'b0, 11'h000, rq);
    endtask

    // Monitor: compares the design against each expected item after the edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(pc == e.pc, int'(e.rq), "pc", int'(pc), int'(e.pc));
                check(busy == e.busy, int'(e.rq), "busy", int'(busy), int'(e.busy));
                check(idle_slot == e.idle, int'(e.rq), "idle_slot", int'(idle_slot), int'(e.idle));
                check(int_en == e.ie, int'(e.rq), "int_en", int'(int_en), int'(e.ie));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mstk[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pc == 11'h000, 1, "pc in reset", int'(pc), 0);
        check(!busy && !idle_slot, 1, "busy/idle in reset", int'({busy, idle_slot}), 0);
        check(!int_en, 1, "int_en in reset", int'(int_en), 0);
        rst_n = 1'b1;
        gap(1);                                    // R1: still at zero after release

        plain(13'h0040, 2); plain(13'h0400, 2); plain(13'h0140, 2);   // R2
        step(1'b1, 13'h0580, 8'h00, 1'b1, 1'b0, 11'h000, 3);          // R3 taken skip
        step(1'b1, 13'h0012, 8'h00, 1'b0, 1'b0, 11'h000, 8);          // R8 ignored while busy
        step(1'b1, 13'h07C0, 8'h00, 1'b0, 1'b0, 11'h000, 3);          // R3 not taken
        step(1'b1, 13'h0400, 8'h00, 1'b1, 1'b0, 11'h000, 3);          // R3 skip_req on non-skip word
        step(1'b1, 13'h05C0, 8'h00, 1'b1, 1'b0, 11'h000, 3);          // R3 DJZ-class taken
        gap(3);
        step(1'b1, 13'h0780, 8'h00, 1'b1, 1'b0, 11'h000, 3);
        step(1'b1, 13'h0040, 8'h00, 1'b1, 1'b0, 11'h000, 8);          // R8

        call_to(11'h123, 4);                                           // R4
        plain(13'h0040, 2);
        step(1'b1, 13'h0012, 8'h00, 1'b0, 1'b1, 11'h555, 4);          // R4: call overrides opcode
        plain(13'h0012, 5);                                            // R5 return
        gap(5);
        plain(13'h0012, 5);
        gap(5);

        call_to(11'h2F0, 4);
        step(1'b1, 13'h0020, 8'h20, 1'b0, 1'b0, 11'h000, 7);          // R7 0x2F1 + 0x20
        gap(7);
        call_to(11'h6FF, 4);
        step(1'b1, 13'h0020, 8'h05, 1'b0, 1'b0, 11'h000, 7);          // R7 base crosses into bit 8
        gap(7);
        call_to(11'h600, 4);
        step(1'b1, 13'h0020, 8'hFF, 1'b0, 1'b0, 11'h000, 7);          // R7 low byte overflow dropped
        step(1'b1, 13'h0013, 8'h00, 1'b0, 1'b0, 11'h000, 8);          // R8 ignored

        plain(13'h0013, 6);                                            // R6 interrupt return
        gap(6);
        plain(13'h0040, 6);                                            // R6 int_en stays set
        plain(13'h0013, 6);
        gap(6);

        // R9: nine nested calls then nine returns
        for (int i = 0; i < 9; i++) call_to(11'(11'h100 + 11'(i * 16)), 9);
        for (int i = 0; i < 9; i++) begin
            plain(13'h0012, 9);
            gap(9);
        end

        call_to(11'h7FF, 4);
        plain(13'h0040, 2);                                            // R2 wrap to zero
        gap(2);
        gap(2);

        @(negedge clk);
        @(negedge clk);
        #5;
        check(exp_q.size() == 0, 2, "scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule